// File: doc/BRIEF.md
# Transmit-Only Synchronous Serial Master

This block shifts fixed-length 8-bit telegrams from a master to a slave. It uses two output pins: one carries the serial data and the other carries the shift clock. There is no receive line. The shift clock is made from a timer tick input. Each accepted tick flips the clock level, so every bit lasts two ticks. Data changes only on the clock edge that the slave does not sample. It is therefore stable when the chosen sampling edge arrives.

A transfer starts with a one-cycle start strobe while the block is idle. The byte, the pin assignment and the sampling polarity are captured at that moment. A mode input chooses which pin carries data and which carries clock. A polarity input chooses whether the slave samples on the rising or the falling clock edge. The block raises a busy flag for the whole telegram. It then returns the clock to its resting level and issues a one-cycle done pulse.

Top module: `ser_tx_master`

## Requirements
- R1: After reset, busy, done and both pins are 0, and the latched configuration is mode 0 with rising-edge sampling.
- R2: A start strobe sampled while idle sets busy in the next cycle. In that same cycle the data line shows bit 7 of the byte, and the clock line rests at its idle level: 0 when `fall_sample`=0, 1 when `fall_sample`=1.
- R3: Each tick sampled while busy inverts the clock line in the next cycle. A tick sampled while idle changes nothing.
- R4: Bits go out MSB first. The data line changes only on even-numbered ticks 2, 4, …, 14, which present bits 6 down to 0.
- R5: With `fall_sample`=0 the slave sees the byte on rising clock edges. With `fall_sample`=1 it sees the byte on falling clock edges.
- R6: With `pin_swap`=0, `pin_a` carries data and `pin_b` carries clock. With `pin_swap`=1 the two are exchanged.
- R7: The 16th tick returns the clock to its idle level and clears busy. It also raises done for exactly one cycle, in the cycle after that tick.
- R8: A start strobe while busy is ignored. The running telegram, its pin mapping and its polarity are unchanged.
- R9: Changes on `pin_swap`, `fall_sample` or `tx_byte` during a transfer have no effect until the next accepted start.
- R10: While idle, the data line holds its last bit and the clock line holds its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send `tx_byte` |
| tx_byte | input | 8 | Telegram to send, MSB first |
| tick | input | 1 | Timer output tick; each one is half a bit period |
| pin_swap | input | 1 | 0: data on `pin_a`, clock on `pin_b`; 1: swapped |
| fall_sample | input | 1 | 0: slave samples on rising edges; 1: on falling edges |
| pin_a | output | 1 | Output pin 1 |
| pin_b | output | 1 | Output pin 2 |
| busy | output | 1 | High while a telegram is in progress |
| done | output | 1 | One-cycle pulse when a telegram completes |

## Verification
Every result is registered exactly once. A start or tick sampled at one rising edge shows up on the pins and on busy right after that same edge, and done follows one edge after the 16th tick. The bench's behavioural model applies the same one-edge latency. Outputs are compared on the falling edge that follows each rising edge, so each cycle's result is checked in the cycle it is due. A separate monitor rebuilds each byte from the pins at the sampling edges. This checks bit order and polarity without relying on cycle counting.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef struct packed {
    logic swap;   // 1: data and clock pins exchanged
    logic fall;   // 1: slave samples on falling edges
  } tx_cfg_t;

  // Resting clock level: opposite to the first sampling edge.
  function automatic logic idle_level(input logic fall);
    return fall;
  endfunction

  // Pin driven by a given line for a given mapping: pin index 0 is pin_a.
  function automatic logic pin_value(input logic swap, input logic data,
                                     input logic sclk, input logic pin_idx);
    logic carries_clk;
    carries_clk = swap ^ pin_idx;
    return carries_clk ? sclk : data;
  endfunction

  // An even-numbered tick (counter odd before it) moves to the next bit.
  function automatic logic is_bit_boundary(input logic cnt_lsb);
    return cnt_lsb;
  endfunction

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    tick_i,
  input  logic    swap_i,
  input  logic    fall_i,
  output logic    busy_o,
  output logic    done_o,
  output logic    launch_o,
  output logic    tick_act_o,
  output logic    shift_o,
  output tx_cfg_t cfg_o
);
  localparam int HALF_N = 2 * WORD_W;
  localparam int CNT_W  = $clog2(HALF_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_N - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] cnt_q;
  tx_cfg_t          cfg_q;
  logic             last_tick;

  assign launch_o   = start_i & ~busy_q;
  assign tick_act_o = tick_i & busy_q;
  assign last_tick  = tick_act_o & (cnt_q == CNT_LAST);
  assign shift_o    = tick_act_o & is_bit_boundary(cnt_q[0]) & ~last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
    end else begin
      done_q <= last_tick;
      if (launch_o) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        cfg_q.swap <= swap_i;
        cfg_q.fall <= fall_i;
      end else if (tick_act_o) begin
        if (last_tick) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end
  end

  assign data_o = sr_q[WORD_W-1];
endmodule

// File: rtl/ser_tx_clkgen.sv
module ser_tx_clkgen
  import ser_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic fall_i,
  input  logic toggle_i,
  output logic sclk_o
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= idle_level(1'b0);
    end else if (load_i) begin
      sclk_q <= idle_level(fall_i);
    end else if (toggle_i) begin
      sclk_q <= ~sclk_q;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/ser_tx_pinmux.sv
module ser_tx_pinmux
  import ser_tx_pkg::*;
#(
  parameter int PIN_N = 2
) (
  input  logic             swap_i,
  input  logic             data_i,
  input  logic             sclk_i,
  output logic [PIN_N-1:0] pins_o
);
  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    assign pins_o[p] = pin_value(swap_i, data_i, sclk_i, 1'(p));
  end
endmodule

// File: rtl/ser_tx_master.sv
module ser_tx_master
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              pin_swap,
  input  logic              fall_sample,
  output logic              pin_a,
  output logic              pin_b,
  output logic              busy,
  output logic              done
);
  localparam int PIN_N = 2;

  tx_cfg_t          cfg;
  logic             launch;
  logic             tick_act;
  logic             shift;
  logic             sdata;
  logic             sclk;
  logic [PIN_N-1:0] pins;

  ser_tx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .tick_i     (tick),
    .swap_i     (pin_swap),
    .fall_i     (fall_sample),
    .busy_o     (busy),
    .done_o     (done),
    .launch_o   (launch),
    .tick_act_o (tick_act),
    .shift_o    (shift),
    .cfg_o      (cfg)
  );

  ser_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (launch),
    .shift_i (shift),
    .word_i  (tx_byte),
    .data_o  (sdata)
  );

  ser_tx_clkgen u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (launch),
    .fall_i   (fall_sample),
    .toggle_i (tick_act),
    .sclk_o   (sclk)
  );

  ser_tx_pinmux #(.PIN_N(PIN_N)) u_mux (
    .swap_i (cfg.swap),
    .data_i (sdata),
    .sclk_i (sclk),
    .pins_o (pins)
  );

  assign pin_a = pins[0];
  assign pin_b = pins[1];
endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tick,
  input logic busy,
  input logic done,
  input logic pin_a,
  input logic pin_b,
  input logic sclk,
  input logic launch,
  input logic tick_act
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R2

  AST_TICK_FLIPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_act |=> (sclk != $past(sclk))); // R3

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(pin_a) && $stable(pin_b))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pin_a) && $stable(pin_b) && !busy)); // R10

  AST_IDLE_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tick && !start) |=> $stable(sclk)); // R3
endmodule

bind ser_tx_master ser_tx_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .tick     (tick),
  .busy     (busy),
  .done     (done),
  .pin_a    (pin_a),
  .pin_b    (pin_b),
  .sclk     (sclk),
  .launch   (launch),
  .tick_act (tick_act)
);

// File: tb/test_ser_tx_master.sv
`timescale 1ns/1ps
module test_ser_tx_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tick = 1'b0;
  logic       pin_swap = 1'b0;
  logic       fall_sample = 1'b0;
  logic       pin_a, pin_b, busy, done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ser_tx_master i_ser_tx_master (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte), .tick(tick),
    .pin_swap(pin_swap), .fall_sample(fall_sample),
    .pin_a(pin_a), .pin_b(pin_b), .busy(busy), .done(done)
  );

  // Behavioural reference model
  bit         m_busy, m_done, m_clk, m_data, m_swap, m_fall;
  int         m_ticks;
  logic [7:0] m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_clk = 0; m_data = 0; m_swap = 0; m_fall = 0;
      m_ticks = 0; m_word = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_word = tx_byte; m_swap = pin_swap; m_fall = fall_sample;
          m_clk = fall_sample; m_data = tx_byte[7]; m_ticks = 0;
        end
      end else if (tick) begin
        m_ticks++;
        m_clk = !m_clk;
        if (m_ticks == 16) begin
          m_busy = 0; m_done = 1;
        end else if (m_ticks % 2 == 0) begin
          m_data = m_word[7 - m_ticks / 2];
        end
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, got, exp, $time);
    end
  endtask

  // Per-cycle comparison and slave-side capture
  bit         prev_clk;
  bit         have_prev = 0;
  logic [7:0] cap;
  logic [7:0] cap_exp;
  string      cap_tag = "R5";

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit clk_pin, dat_pin;
      check(busy, m_busy, "R2/R7 busy");
      check(done, m_done, "R7 done");
      check(pin_a, m_swap ? m_clk : m_data, "R3/R4/R6 pin_a");
      check(pin_b, m_swap ? m_data : m_clk, "R3/R4/R6 pin_b");
      clk_pin = m_swap ? pin_a : pin_b;
      dat_pin = m_swap ? pin_b : pin_a;
      if (have_prev && busy && clk_pin != prev_clk && clk_pin == !m_fall)
        cap = {cap[6:0], dat_pin};
      if (done) begin
        tests++;
        if (cap !== cap_exp) begin
          fails++;
          $display("FAIL %s captured byte: actual %02h expected %02h", cap_tag, cap, cap_exp);
        end
      end
      prev_clk = clk_pin;
      have_prev = 1;
    end
  end

  task automatic send(input logic [7:0] b, input bit sw, input bit fl,
                      input int gap, input bit disturb, input string tag);
    @(negedge clk);
    start = 1; tx_byte = b; pin_swap = sw; fall_sample = fl;
    cap_exp = b; cap = 8'h00; cap_tag = tag;
    @(negedge clk);
    start = 0;
    // R2 / R6: first cycle after launch
    check(sw ? pin_a : pin_b, fl, "R2 idle clock level");
    check(sw ? pin_b : pin_a, b[7], "R2/R6 MSB on data pin");
    for (int t = 0; t < 16; t++) begin
      tick = 1;
      if (disturb && t == 5) begin
        start = 1; tx_byte = ~b; pin_swap = !sw; fall_sample = !fl; // R8 R9
      end
      @(negedge clk);
      tick = 0; start = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    pin_swap = sw; fall_sample = fl;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy, 0, "R1 busy"); check(done, 0, "R1 done");
    check(pin_a, 0, "R1 pin_a"); check(pin_b, 0, "R1 pin_b");
    rst_n = 1;
    // R3 ticks while idle
    for (int i = 0; i < 4; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
      check(pin_b, 0, "R3 idle tick clock"); check(busy, 0, "R3 idle tick busy");
    end
    send(8'hB4, 0, 0, 2, 0, "R5 rising");
    send(8'h49, 1, 1, 1, 0, "R5/R6 falling swapped");
    send(8'h9B, 0, 1, 0, 0, "R4 back-to-back ticks");
    send(8'hA5, 1, 0, 3, 1, "R8/R9 ignored");
    send(8'hFF, 0, 0, 0, 0, "R4 all ones");
    // R10 idle hold after all ones: data 1, clock low
    for (int i = 0; i < 5; i++) begin
      tick = (i % 2 == 0); @(negedge clk);
      check(pin_a, 1, "R10 data holds last bit");
      check(pin_b, 0, "R10 clock rests idle");
    end
    tick = 0;
    send(8'h00, 1, 1, 1, 1, "R8/R9 zeros");
    send(8'h81, 0, 1, 2, 0, "R5 falling");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule